// File: doc/BRIEF.md
# DAC Serial Command Sequencer with Power-Up Reference Enable

This block drives the three-wire, write-only serial port of an eight-channel DAC. Every transfer is a 32-bit word sent most significant bit first. A frame-select line, active low, brackets each word. After reset the block waits a set number of system clocks. It may then send a configurable software-reset word. It then sends the word that switches on the DAC's internal voltage reference. Only after that does it open its host port.

From then on the host presents 32-bit command words on a valid/ready port. The block forwards each word unchanged as one frame. The serial clock comes from dividing the system clock. It rests high between frames. Data is launched on the rising edge and captured by the DAC on the falling edge, so every falling edge sits in the middle of a bit. The frame select is released only after the 32nd falling edge, which is the edge on which the DAC acts on the word.

Top module: `dac_cmd_serializer`

## Requirements
- R1: While reset is asserted, dacSclk is 1, dacSyncN is 1, dacDin is 0, cmdReady is 0 and initDone is 0.
- R2: dacSyncN stays high for at least PWR_WAIT system clocks after reset is released.
- R3: With SEND_RST set, the first frame after reset carries the word RST_WORD.
- R4: The frame that follows (the first frame when SEND_RST is clear) is 0x08000001. This is command code 8 in bits 27:24, zero in bits 31:28, and a 1 in bit 0, which switches the internal reference on.
- R5: Every frame has exactly 32 falling dacSclk edges while dacSyncN is low. The bit captured on the first falling edge is bit 31 and the bit captured on the last is bit 0.
- R6: While dacSyncN is low, dacDin changes only in the same cycle as a rising dacSclk edge, never at a falling edge.
- R7: The first falling dacSclk edge comes HALF_DIV system clocks after dacSyncN falls. dacSyncN rises HALF_DIV system clocks after the 32nd falling edge.
- R8: Between two frames, dacSyncN stays high for at least 2*HALF_DIV system clocks, which is one full serial clock period.
- R9: cmdReady is 0 until initDone is 1, and it is 0 whenever dacSyncN is low. A word held valid before initialization finishes is neither lost nor sent early.
- R10: initDone is 0 through the end of the reference-enable frame, rises after that frame, and then stays 1.
- R11: dacSclk is 1 whenever dacSyncN is 1.
- R12: Every low phase of dacSclk lasts exactly HALF_DIV system clocks.
- R13: A host word accepted on a cycle where cmdValid and cmdReady are both 1 appears bit for bit as the next frame. Words appear in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdData | input | 32 | Host command word |
| cmdValid | input | 1 | Host word valid |
| cmdReady | output | 1 | Block can accept a host word this cycle |
| dacSclk | output | 1 | Serial clock to the DAC, idles high |
| dacDin | output | 1 | Serial data to the DAC, launched on the rising edge |
| dacSyncN | output | 1 | Frame select, active low |
| initDone | output | 1 | Power-up sequence has finished |

## Verification
The assertions assume the host follows the valid/ready rule: once cmdValid rises, cmdData holds steady until the handshake cycle. They also assume rstN is held for at least one clock before the first frame is judged. The bench changes cmdData and cmdValid only on falling system-clock edges. It keeps each word stable until it sees cmdReady high and the handshake edge has passed. It drives reset from time zero.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int FRAME_BITS = 32;
  localparam logic [3:0] CMD_REF_SETUP = 4'h8;
  localparam logic [FRAME_BITS-1:0] REF_ON_WORD = {4'h0, CMD_REF_SETUP, 23'd0, 1'b1};

  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_RST  = 2'd1,
    SRC_REF  = 2'd2
  } wordSrc_t;

  typedef struct packed {
    logic     load;
    wordSrc_t src;
  } seqStrobe_t;
endpackage

// File: rtl/dacseq_shifter.sv
module dacseq_shifter
  import dacseq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter logic [FRAME_BITS-1:0] RST_WORD = 32'h0700_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [FRAME_BITS-1:0] hostWord,
  output logic                  busy,
  output logic                  frameDone,
  output logic                  sclk,
  output logic                  din,
  output logic                  syncN
);
  localparam int HALF_STEPS = 2 * FRAME_BITS + 2;
  localparam int LAST_FALL  = 2 * FRAME_BITS - 2;
  localparam int SYNC_REL   = LAST_FALL + 1;
  localparam int HC_W       = $clog2(HALF_STEPS);
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [FRAME_BITS-1:0] shReg;
  logic [FRAME_BITS-1:0] nextWord;
  logic [HC_W-1:0]       hCnt;
  logic [DIV_W-1:0]      divCnt;
  logic                  active;
  logic                  tick;

  always_comb begin
    case (strobe.src)
      SRC_RST: nextWord = RST_WORD;
      SRC_REF: nextWord = REF_ON_WORD;
      default: nextWord = hostWord;
    endcase
  end

  assign tick = active && (divCnt == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      hCnt      <= '0;
      divCnt    <= '0;
      active    <= 1'b0;
      sclk      <= 1'b1;
      syncN     <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobe.load && !active) begin
        shReg  <= nextWord;
        hCnt   <= '0;
        divCnt <= '0;
        active <= 1'b1;
        sclk   <= 1'b1;
        syncN  <= 1'b0;
      end else if (tick) begin
        divCnt <= '0;
        hCnt   <= hCnt + 1'b1;
        if (hCnt == HC_W'(SYNC_REL)) begin
          sclk  <= 1'b1;
          syncN <= 1'b1;
          shReg <= '0;
        end else if (hCnt == HC_W'(HALF_STEPS - 1)) begin
          active    <= 1'b0;
          frameDone <= 1'b1;
        end else if (hCnt < HC_W'(SYNC_REL)) begin
          if (!hCnt[0]) begin
            sclk <= 1'b0;
          end else begin
            sclk  <= 1'b1;
            shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
          end
        end
      end else if (active) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign din  = shReg[FRAME_BITS-1];
  assign busy = active;
endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int PWR_WAIT = 16,
  parameter bit SEND_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       frameDone,
  input  logic       cmdValid,
  output logic       cmdReady,
  output logic       initDone,
  output seqStrobe_t strobe
);
  localparam int WAIT_W = $clog2(PWR_WAIT + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_RST_GO, ST_RST_WAIT, ST_REF_GO, ST_REF_WAIT, ST_RUN
  } ctrlState_t;

  ctrlState_t      state;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PWR;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_PWR: begin
          if (waitCnt == WAIT_W'(PWR_WAIT - 1)) begin
            state <= SEND_RST ? ST_RST_GO : ST_REF_GO;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RST_GO:   state <= ST_RST_WAIT;
        ST_RST_WAIT: if (frameDone) state <= ST_REF_GO;
        ST_REF_GO:   state <= ST_REF_WAIT;
        ST_REF_WAIT: if (frameDone) state <= ST_RUN;
        default:     state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe = '{load: 1'b0, src: SRC_HOST};
    case (state)
      ST_RST_GO: strobe = '{load: 1'b1, src: SRC_RST};
      ST_REF_GO: strobe = '{load: 1'b1, src: SRC_REF};
      ST_RUN:    strobe = '{load: cmdValid && !busy, src: SRC_HOST};
      default:   strobe = '{load: 1'b0, src: SRC_HOST};
    endcase
  end

  assign cmdReady = (state == ST_RUN) && !busy;
  assign initDone = (state == ST_RUN);
endmodule

// File: rtl/dac_cmd_serializer.sv
module dac_cmd_serializer
  import dacseq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PWR_WAIT = 16,
  parameter bit SEND_RST = 1'b1,
  parameter logic [31:0] RST_WORD = 32'h0700_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cmdData,
  input  logic        cmdValid,
  output logic        cmdReady,
  output logic        dacSclk,
  output logic        dacDin,
  output logic        dacSyncN,
  output logic        initDone
);
  seqStrobe_t strobe;
  logic       busy;
  logic       frameDone;

  dacseq_ctrl #(.PWR_WAIT(PWR_WAIT), .SEND_RST(SEND_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .busy(busy), .frameDone(frameDone),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .initDone(initDone),
    .strobe(strobe)
  );

  dacseq_shifter #(.HALF_DIV(HALF_DIV), .RST_WORD(RST_WORD)) u_shift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWord(cmdData),
    .busy(busy), .frameDone(frameDone), .sclk(dacSclk), .din(dacDin),
    .syncN(dacSyncN)
  );
endmodule

// File: rtl/dac_cmd_serializer_chk.sv
module dac_cmd_serializer_chk #(
  parameter int HALF_DIV = 2,
  parameter int PWR_WAIT = 16
) (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic dacSclk,
  input logic dacDin,
  input logic dacSyncN,
  input logic initDone
);
  logic        prevSclk, prevSync, prevDin, seenFrame;
  logic [5:0]  falls;
  logic [15:0] gapCnt;
  logic [31:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSclk  <= 1'b1;
      prevSync  <= 1'b1;
      prevDin   <= 1'b0;
      seenFrame <= 1'b0;
      falls     <= '0;
      gapCnt    <= '0;
      sinceRst  <= '0;
    end else begin
      prevSclk <= dacSclk;
      prevSync <= dacSyncN;
      prevDin  <= dacDin;
      if (sinceRst != 32'hFFFF_FFFF) sinceRst <= sinceRst + 1'b1;
      if (!dacSyncN && prevSync) begin
        falls <= '0;
      end else if (!dacSyncN && prevSclk && !dacSclk) begin
        falls <= falls + 1'b1;
      end
      if (dacSyncN && !prevSync) seenFrame <= 1'b1;
      if (dacSyncN) begin
        if (gapCnt != 16'hFFFF) gapCnt <= gapCnt + 1'b1;
      end else begin
        gapCnt <= '0;
      end
    end
  end

  a_r11_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    dacSyncN |-> dacSclk);
  a_r9_not_ready_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !dacSyncN |-> !cmdReady);
  a_r9_ready_after_init: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> initDone);
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  a_r6_din_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!dacSyncN && !prevSync && (dacDin != prevDin)) |-> (dacSclk && !prevSclk));
  a_r5_thirty_two_falls: assert property (@(posedge clk) disable iff (!rstN)
    (dacSyncN && !prevSync) |-> (falls == 6'd32));
  a_r8_gap_full_period: assert property (@(posedge clk) disable iff (!rstN)
    (!dacSyncN && prevSync && seenFrame) |-> (gapCnt >= 16'(2 * HALF_DIV)));
  a_r2_power_wait: assert property (@(posedge clk) disable iff (!rstN)
    !dacSyncN |-> (sinceRst >= 32'(PWR_WAIT)));
endmodule

bind dac_cmd_serializer dac_cmd_serializer_chk #(
  .HALF_DIV(HALF_DIV), .PWR_WAIT(PWR_WAIT)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .dacSclk(dacSclk),
  .dacDin(dacDin), .dacSyncN(dacSyncN), .initDone(initDone)
);

// File: tb/test_dac_cmd_serializer.sv
module test_dac_cmd_serializer;
  localparam int HALF = 2;
  localparam int PWRW = 20;
  localparam logic [31:0] RSTW = 32'h0700_0000;
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0300_0ABC, 32'h0F7F_FFF0, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0A5A_5A5A, 32'h0215_8001
  };

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [31:0] cmdData = '0;
  logic cmdReady, dacSclk, dacDin, dacSyncN, initDone;

  always #2.5 clk = ~clk;

  dac_cmd_serializer #(.HALF_DIV(HALF), .PWR_WAIT(PWRW), .SEND_RST(1'b1),
    .RST_WORD(RSTW)) i_dac_cmd_serializer (
    .clk(clk), .rstN(rstN), .cmdData(cmdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .dacSclk(dacSclk), .dacDin(dacDin),
    .dacSyncN(dacSyncN), .initDone(initDone));

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  logic [31:0] capWord [16];
  int capFalls [16];
  int nFrames = 0, cyc = 0, firstSyncCyc = -1;
  int syncFallCyc = 0, syncRiseCyc = 0, lastFallCyc = 0, lowStart = 0;
  int falls = 0, minGap = 1000000;
  int leadBad = 0, tailBad = 0, lowBad = 0, dinBad = 0, readyBad = 0, idleBad = 0;
  bit firstFall = 0, doneAtRefEnd = 0;
  logic [31:0] bits = '0;
  logic pSclk = 1'b1, pSync = 1'b1, pDin = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (pSync && !dacSyncN) begin
        syncFallCyc = cyc; bits = '0; falls = 0; firstFall = 1;
        if (firstSyncCyc < 0) firstSyncCyc = cyc;
        if (nFrames > 0 && (cyc - syncRiseCyc) < minGap) minGap = cyc - syncRiseCyc;
      end
      if (!dacSyncN && pSclk && !dacSclk) begin
        bits = {bits[30:0], dacDin}; falls++;
        if (firstFall && (cyc - syncFallCyc) != HALF) leadBad++;
        firstFall = 0; lastFallCyc = cyc; lowStart = cyc;
      end
      if (!pSclk && dacSclk && (cyc - lowStart) != HALF) lowBad++;
      if (!dacSyncN && !pSync && dacDin != pDin && !(dacSclk && !pSclk)) dinBad++;
      if (cmdReady && (!dacSyncN || !initDone)) readyBad++;
      if (dacSyncN && !dacSclk) idleBad++;
      if (!pSync && dacSyncN) begin
        if ((cyc - lastFallCyc) != HALF) tailBad++;
        if (nFrames < 16) begin capWord[nFrames] = bits; capFalls[nFrames] = falls; end
        if (nFrames == 1) doneAtRefEnd = initDone;
        nFrames++; syncRiseCyc = cyc;
      end
      pSclk = dacSclk; pSync = dacSyncN; pDin = dacDin;
    end
  end

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    cmdData = w; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", nFrames, NVEC + 2);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dacSclk == 1'b1 && dacSyncN == 1'b1 && dacDin == 1'b0, "R1 serial idle",
          {dacSclk, dacSyncN, dacDin}, 3'b110);
    check(cmdReady == 1'b0 && initDone == 1'b0, "R1 status low",
          {cmdReady, initDone}, 0);
    rstN = 1'b1;
    // vector table walk; first word held before init (R9)
    for (int i = 0; i < NVEC; i++) sendWord(VEC[i]);
    while (nFrames < NVEC + 2) @(negedge clk);
    repeat (4) @(negedge clk);

    check(firstSyncCyc >= PWRW, "R2 power-up wait", firstSyncCyc, PWRW);
    check(capWord[0] == RSTW, "R3 reset frame", capWord[0], RSTW);
    check(capWord[1] == 32'h0800_0001, "R4 reference enable", capWord[1], 32'h0800_0001);
    check(capWord[1][27:24] == 4'h8 && capWord[1][31:28] == 4'h0, "R4 command field",
          capWord[1][31:24], 8'h08);
    for (int i = 0; i < NVEC + 2; i++)
      check(capFalls[i] == 32, "R5 falls per frame", capFalls[i], 32);
    for (int i = 0; i < NVEC; i++)
      check(capWord[i+2] == VEC[i], "R13 host word", capWord[i+2], VEC[i]);
    check(dinBad == 0, "R6 din on rising edge", dinBad, 0);
    check(leadBad == 0, "R7 sync to first fall", leadBad, 0);
    check(tailBad == 0, "R7 last fall to sync release", tailBad, 0);
    check(minGap >= 2 * HALF, "R8 inter-frame gap", minGap, 2 * HALF);
    check(readyBad == 0, "R9 ready gating", readyBad, 0);
    check(doneAtRefEnd == 1'b0, "R10 done low through ref frame", doneAtRefEnd, 0);
    check(initDone == 1'b1, "R10 done high", initDone, 1);
    check(idleBad == 0, "R11 sclk idles high", idleBad, 0);
    check(lowBad == 0, "R12 sclk low width", lowBad, 0);
    finishRun();
  end
endmodule